// File: doc/BRIEF.md
# Dual-Style Expansion Bus Master

This block runs one read or one write at a time on a multiplexed address/data expansion bus. An internal client presents an address, write data and a direction bit with a valid flag. The master first asks for ownership of the bus and waits until ownership is granted. It then drives the address and after that the data phase. At the end it frees the bus and answers the client with a one-clock acknowledge. Read data comes back on the same acknowledge.

A runtime mode bit picks the handshake family. With the bit high the master uses Intel-style signalling: a hold request and hold acknowledge, an address latch enable, and separate read and write strobes. With the bit low it uses Motorola-style signalling: a bus request and bus grant, an address strobe, a read/write direction line and a single data strobe. Two separate duration fields stretch the address phase and the data phase on their own. The master samples the mode bit and both fields when it accepts a request, and it keeps those values until the cycle ends.

Top module: `xbus_master`

## Requirements
- R1: While reset is high and after it is released, hold is 0, every active-low line (breq_n, ale_n, rd_n, wr_n, as_n, ds_n) is 1, rw is 1, ad_oe is 0 and req_ack is 0.
- R2: After accepting a request the master raises its bus request (hold=1 in Intel mode, breq_n=0 in Motorola mode). It keeps ad_oe at 0 and all strobes inactive until the grant is seen (hlda=1 or bgnt_n=0). The first address clock follows the clock in which the grant was sampled.
- R3: The address phase lasts cfg_adur+1 clocks. During it, ad_oe is 1 and ad_out carries the request address.
- R4: The data phase lasts cfg_ddur+1 clocks and follows the address phase directly. For a write, ad_oe is 1 and ad_out carries the write data. For a read, ad_oe is 0.
- R5: In Intel mode, ale_n is low only on the last address clock. The strobe for the direction (wr_n for a write, rd_n for a read) is low only on the last data clock, and the other strobe never falls. The Motorola lines stay idle (breq_n=1, as_n=1, ds_n=1, rw=1).
- R6: In Motorola mode, as_n is low from the last address clock through the end of the data phase. ds_n is low only on the last data clock. rw is 0 for a write and 1 for a read at that strobe. The Intel lines stay idle (hold=0, ale_n=1, rd_n=1, wr_n=1).
- R7: For a read, ad_in is captured on the last data clock. req_ack is high for exactly one clock, the clock right after that strobe, and req_rdata holds the captured value at that time.
- R8: The bus request is released in the acknowledge clock. Between two cycles there is at least one clock in which no request is raised, even if req_valid stays high.
- R9: cfg_intel, cfg_adur and cfg_ddur are sampled when a request is accepted. A change to them during a cycle does not alter that cycle's signalling style or phase lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Expansion clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Client request pending |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AD_W | Cycle address |
| req_wdata | input | AD_W | Write data |
| req_ack | output | 1 | One-clock completion pulse |
| req_rdata | output | AD_W | Read data, valid with req_ack |
| cfg_intel | input | 1 | 1 = Intel-style, 0 = Motorola-style |
| cfg_adur | input | ADUR_W | Address phase length minus one |
| cfg_ddur | input | DDUR_W | Data phase length minus one |
| hold | output | 1 | Intel hold request, active high |
| hlda | input | 1 | Intel hold acknowledge, active high |
| breq_n | output | 1 | Motorola bus request, active low |
| bgnt_n | input | 1 | Motorola bus grant, active low |
| ale_n | output | 1 | Intel address latch enable, active low |
| rd_n | output | 1 | Intel read strobe, active low |
| wr_n | output | 1 | Intel write strobe, active low |
| as_n | output | 1 | Motorola address strobe, active low |
| ds_n | output | 1 | Motorola data strobe, active low |
| rw | output | 1 | Motorola direction, 1 = read |
| ad_out | output | AD_W | Multiplexed bus, driven value |
| ad_oe | output | 1 | Bus output enable |
| ad_in | input | AD_W | Multiplexed bus, sampled value |

## Verification
The bench uses the default widths: a 16-bit multiplexed bus, a 2-bit address duration and a 3-bit data duration. With these widths every corner of both fields can be reached, from single-clock phases up to the longest setting of four address clocks and eight data clocks, in both styles. Grant delays of zero to three clocks test the wait before ownership. A mid-cycle flip of the mode bit and both fields checks the sampling rule. A request held high across two cycles checks the idle clock between them.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int ADUR_W = 2;
    localparam int DDUR_W = 3;
    localparam int CNT_W  = (DDUR_W > ADUR_W) ? DDUR_W : ADUR_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_ADDR,
        ST_DATA,
        ST_END
    } xb_state_e;

    // Per-cycle control, frozen when a request is accepted
    typedef struct packed {
        logic              intel;
        logic              write;
        logic [ADUR_W-1:0] adur;
        logic [DDUR_W-1:0] ddur;
    } xb_ctl_t;

    // Pin image produced by the strobe decoder
    typedef struct packed {
        logic hold;
        logic breq_n;
        logic ale_n;
        logic rd_n;
        logic wr_n;
        logic as_n;
        logic ds_n;
        logic rw;
        logic oe;
        logic drive_addr;
    } xb_pins_t;

    function automatic logic grant_seen(input logic intel,
                                        input logic hlda,
                                        input logic bgnt_n);
        return intel ? hlda : ~bgnt_n;
    endfunction

endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              granted,
    input  logic [ADUR_W-1:0] adur,
    input  logic [DDUR_W-1:0] ddur,
    output xb_state_e         state,
    output logic              last
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) state <= ST_REQ;
                end
                ST_REQ: begin
                    if (granted) begin
                        state <= ST_ADDR;
                        cnt   <= CNT_W'(adur);
                    end
                end
                ST_ADDR: begin
                    if (cnt == '0) begin
                        state <= ST_DATA;
                        cnt   <= CNT_W'(ddur);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_DATA: begin
                    if (cnt == '0) state <= ST_END;
                    else           cnt   <= cnt - 1'b1;
                end
                ST_END:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign last = (cnt == '0);

endmodule

// File: rtl/xbus_capture.sv
module xbus_capture
    import xbus_pkg::*;
#(
    parameter int AD_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            accept,
    input  xb_ctl_t         ctl_d,
    input  logic [AD_W-1:0] addr_d,
    input  logic [AD_W-1:0] wdata_d,
    input  logic            cap_en,
    input  logic [AD_W-1:0] ad_in,
    output xb_ctl_t         ctl_q,
    output logic [AD_W-1:0] addr_q,
    output logic [AD_W-1:0] wdata_q,
    output logic [AD_W-1:0] rdata_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            ctl_q   <= ctl_d;
            addr_q  <= addr_d;
            wdata_q <= wdata_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (cap_en) rdata_q <= ad_in;
    end

endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
    import xbus_pkg::*;
(
    input  xb_state_e state,
    input  logic      last,
    input  xb_ctl_t   ctl,
    output xb_pins_t  pins
);

    logic owning;
    logic addr_end;
    logic data_end;
    logic in_cycle;

    always_comb begin
        owning   = (state == ST_REQ) || (state == ST_ADDR) || (state == ST_DATA);
        in_cycle = (state == ST_ADDR) || (state == ST_DATA);
        addr_end = (state == ST_ADDR) && last;
        data_end = (state == ST_DATA) && last;

        pins            = '0;
        pins.hold       = 1'b0;
        pins.breq_n     = 1'b1;
        pins.ale_n      = 1'b1;
        pins.rd_n       = 1'b1;
        pins.wr_n       = 1'b1;
        pins.as_n       = 1'b1;
        pins.ds_n       = 1'b1;
        pins.rw         = 1'b1;
        pins.drive_addr = (state == ST_ADDR);
        pins.oe         = (state == ST_ADDR) || ((state == ST_DATA) && ctl.write);

        if (ctl.intel) begin
            pins.hold  = owning;
            pins.ale_n = ~addr_end;
            pins.rd_n  = ~(data_end && !ctl.write);
            pins.wr_n  = ~(data_end && ctl.write);
        end else begin
            pins.breq_n = ~owning;
            pins.as_n   = ~(addr_end || (state == ST_DATA));
            pins.ds_n   = ~data_end;
            pins.rw     = in_cycle ? ~ctl.write : 1'b1;
        end
    end

endmodule

// File: rtl/xbus_master.sv
module xbus_master
    import xbus_pkg::*;
#(
    parameter int AD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AD_W-1:0]   req_addr,
    input  logic [AD_W-1:0]   req_wdata,
    output logic              req_ack,
    output logic [AD_W-1:0]   req_rdata,
    input  logic              cfg_intel,
    input  logic [ADUR_W-1:0] cfg_adur,
    input  logic [DDUR_W-1:0] cfg_ddur,
    output logic              hold,
    input  logic              hlda,
    output logic              breq_n,
    input  logic              bgnt_n,
    output logic              ale_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              as_n,
    output logic              ds_n,
    output logic              rw,
    output logic [AD_W-1:0]   ad_out,
    output logic              ad_oe,
    input  logic [AD_W-1:0]   ad_in
);

    xb_state_e       state;
    logic            last;
    logic            accept;
    logic            granted;
    logic            cap_en;
    xb_ctl_t         ctl_d;
    xb_ctl_t         ctl_q;
    logic [AD_W-1:0] addr_q;
    logic [AD_W-1:0] wdata_q;
    xb_pins_t        pins;

    assign accept  = (state == ST_IDLE) && req_valid;
    assign granted = grant_seen(ctl_q.intel, hlda, bgnt_n);
    assign cap_en  = (state == ST_DATA) && last && !ctl_q.write;

    always_comb begin
        ctl_d       = '0;
        ctl_d.intel = cfg_intel;
        ctl_d.write = req_write;
        ctl_d.adur  = cfg_adur;
        ctl_d.ddur  = cfg_ddur;
    end

    xbus_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (accept),
        .granted (granted),
        .adur    (ctl_q.adur),
        .ddur    (ctl_q.ddur),
        .state   (state),
        .last    (last)
    );

    xbus_capture #(.AD_W(AD_W)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .ctl_d   (ctl_d),
        .addr_d  (req_addr),
        .wdata_d (req_wdata),
        .cap_en  (cap_en),
        .ad_in   (ad_in),
        .ctl_q   (ctl_q),
        .addr_q  (addr_q),
        .wdata_q (wdata_q),
        .rdata_q (req_rdata)
    );

    xbus_pins u_pins (
        .state (state),
        .last  (last),
        .ctl   (ctl_q),
        .pins  (pins)
    );

    assign req_ack = (state == ST_END);
    assign hold    = pins.hold;
    assign breq_n  = pins.breq_n;
    assign ale_n   = pins.ale_n;
    assign rd_n    = pins.rd_n;
    assign wr_n    = pins.wr_n;
    assign as_n    = pins.as_n;
    assign ds_n    = pins.ds_n;
    assign rw      = pins.rw;
    assign ad_oe   = pins.oe;
    assign ad_out  = pins.drive_addr ? addr_q : wdata_q;

endmodule

// File: rtl/xbus_master_chk.sv
module xbus_master_chk (
    input logic clk,
    input logic rst,
    input logic req_ack,
    input logic hold,
    input logic breq_n,
    input logic ale_n,
    input logic rd_n,
    input logic wr_n,
    input logic as_n,
    input logic ds_n,
    input logic ad_oe
);

    // R2
    oe_needs_request_chk: assert property (@(posedge clk) disable iff (rst)
        ad_oe |-> (hold || !breq_n));

    // R5
    ale_single_clock_chk: assert property (@(posedge clk) disable iff (rst)
        !ale_n |=> ale_n);

    // R5
    strobes_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    // R4
    read_strobe_released_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe);

    // R4
    write_strobe_driven_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> ad_oe);

    // R6
    ds_inside_as_chk: assert property (@(posedge clk) disable iff (rst)
        !ds_n |-> !as_n);

    // R7
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> !req_ack);

    // R8
    ack_request_free_chk: assert property (@(posedge clk) disable iff (rst)
        req_ack |-> (!hold && breq_n));

endmodule

bind xbus_master xbus_master_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .req_ack (req_ack),
    .hold    (hold),
    .breq_n  (breq_n),
    .ale_n   (ale_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .as_n    (as_n),
    .ds_n    (ds_n),
    .ad_oe   (ad_oe)
);

// File: tb/sim_xbus_master.sv
`timescale 1ns/1ps
module sim_xbus_master;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ack;
    logic [15:0] req_rdata;
    logic        cfg_intel = 1'b1;
    logic [1:0]  cfg_adur = '0;
    logic [2:0]  cfg_ddur = '0;
    logic        hold;
    logic        hlda = 1'b0;
    logic        breq_n;
    logic        bgnt_n = 1'b1;
    logic        ale_n, rd_n, wr_n, as_n, ds_n, rw;
    logic [15:0] ad_out;
    logic        ad_oe;
    logic [15:0] ad_in = '0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    xbus_master #(.AD_W(16)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
        .req_rdata(req_rdata), .cfg_intel(cfg_intel), .cfg_adur(cfg_adur),
        .cfg_ddur(cfg_ddur), .hold(hold), .hlda(hlda), .breq_n(breq_n),
        .bgnt_n(bgnt_n), .ale_n(ale_n), .rd_n(rd_n), .wr_n(wr_n),
        .as_n(as_n), .ds_n(ds_n), .rw(rw), .ad_out(ad_out), .ad_oe(ad_oe),
        .ad_in(ad_in)
    );

    typedef struct packed {
        logic        intel;
        logic        write;
        logic [1:0]  adur;
        logic [2:0]  ddur;
        logic [15:0] addr;
        logic [15:0] wdata;
        logic [15:0] rdv;
        logic [3:0]  gdly;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b1, 2'd0, 3'd0, 16'h1234, 16'hABCD, 16'h0000, 4'd0},
        '{1'b1, 1'b0, 2'd3, 3'd7, 16'h2001, 16'h0000, 16'h5A5A, 4'd0},
        '{1'b0, 1'b1, 2'd1, 3'd2, 16'h3003, 16'h7777, 16'h0000, 4'd3},
        '{1'b0, 1'b0, 2'd2, 3'd0, 16'h4004, 16'h0000, 16'hC3C3, 4'd0},
        '{1'b1, 1'b0, 2'd0, 3'd4, 16'h5005, 16'h0000, 16'h0F0F, 4'd2},
        '{1'b0, 1'b1, 2'd3, 3'd7, 16'h6006, 16'h1111, 16'h0000, 4'd1}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_grant(input bit g);
        hlda   = g;
        bgnt_n = !g;
    endtask

    task automatic run(input vec_t v, input bit flip, input bit keep);
        int rq, n_req, n_addr, n_oe, n_astb, n_dstb, a_idx, d_idx, ack_idx;
        int bad, pre_bad, rw_bad, wd_bad;
        int e_ack, e_oe;
        logic [15:0] rd_got;
        bit ra, astb, dstb;
        rq = (v.gdly == 0) ? 1 : int'(v.gdly);
        cfg_intel = v.intel; cfg_adur = v.adur; cfg_ddur = v.ddur;
        req_write = v.write; req_addr = v.addr; req_wdata = v.wdata;
        ad_in = v.rdv;
        set_grant(v.gdly == 0);
        req_valid = 1'b1;
        n_req = 0; n_addr = 0; n_oe = 0; n_astb = 0; n_dstb = 0;
        a_idx = -1; d_idx = -1; ack_idx = -1;
        bad = 0; pre_bad = 0; rw_bad = 0; wd_bad = 0; rd_got = '0;
        for (int idx = 0; idx < 100 && ack_idx < 0; idx++) begin
            @(negedge clk);
            ra   = v.intel ? hold : !breq_n;
            astb = v.intel ? !ale_n : !as_n;
            dstb = v.intel ? (v.write ? !wr_n : !rd_n) : !ds_n;
            if (ra) n_req++;
            if (ad_oe && ad_out == v.addr) n_addr++;
            if (ad_oe) n_oe++;
            if (astb) begin n_astb++; if (a_idx < 0) a_idx = idx; end
            if (dstb) begin n_dstb++; d_idx = idx; end
            if (idx < rq && (ad_oe || astb || dstb)) pre_bad++;
            if (v.intel) begin
                if (v.write ? !rd_n : !wr_n) bad++;
                if (!breq_n || !as_n || !ds_n || !rw) bad++;
            end else begin
                if (hold || !ale_n || !rd_n || !wr_n) bad++;
                if (dstb && rw != !v.write) rw_bad++;
            end
            if (dstb && v.write && !(ad_oe && ad_out == v.wdata)) wd_bad++;
            if (req_ack) begin
                ack_idx = idx;
                rd_got  = req_rdata;
                if (ra) bad++;
            end
            if (flip && idx == 1) begin
                cfg_intel = !v.intel; cfg_adur = ~v.adur; cfg_ddur = ~v.ddur;
            end
            if (v.gdly != 0 && idx == int'(v.gdly) - 1) set_grant(1'b1);
        end
        if (!keep) req_valid = 1'b0;
        e_ack = rq + int'(v.adur) + int'(v.ddur) + 2;
        e_oe  = v.write ? int'(v.adur) + int'(v.ddur) + 2 : int'(v.adur) + 1;
        chk(ack_idx == e_ack, "R7", "ack clock", ack_idx, e_ack);
        chk(pre_bad == 0, "R2", "activity before grant", pre_bad, 0);
        chk(n_req == e_ack, "R2", "request clocks", n_req, e_ack);
        chk(n_addr == int'(v.adur) + 1, "R3", "address clocks", n_addr, int'(v.adur) + 1);
        chk(n_oe == e_oe, "R4", "drive clocks", n_oe, e_oe);
        chk(n_dstb == 1 && d_idx == e_ack - 1, "R4", "data strobe clock", d_idx, e_ack - 1);
        chk(wd_bad == 0, "R4", "write data at strobe", wd_bad, 0);
        if (v.intel) begin
            chk(n_astb == 1 && a_idx == rq + int'(v.adur), "R5", "ale clock", a_idx, rq + int'(v.adur));
            chk(bad == 0, "R5", "idle/wrong lines", bad, 0);
        end else begin
            chk(n_astb == int'(v.ddur) + 2 && a_idx == rq + int'(v.adur), "R6", "as_n span", n_astb, int'(v.ddur) + 2);
            chk(bad == 0 && rw_bad == 0, "R6", "idle lines / rw", bad + rw_bad, 0);
        end
        if (!v.write)
            chk(rd_got == v.rdv, "R7", "read data", int'(rd_got), int'(v.rdv));
        if (flip)
            chk(ack_idx == e_ack && bad == 0, "R9", "frozen config", ack_idx, e_ack);
        cfg_intel = v.intel; cfg_adur = v.adur; cfg_ddur = v.ddur;
        if (keep) begin
            @(negedge clk);
            ra = v.intel ? hold : !breq_n;
            chk(!ra && !ad_oe && !req_ack, "R8", "idle clock after ack", int'(ra), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        vec_t fv;
        vec_t kv;
        repeat (3) @(negedge clk);
        // R1: values during reset
        chk(!hold && breq_n && ale_n && rd_n && wr_n && as_n && ds_n && rw && !ad_oe && !req_ack,
            "R1", "reset pins", int'(ad_oe), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!hold && breq_n && ale_n && rd_n && wr_n && as_n && ds_n && rw && !ad_oe && !req_ack,
            "R1", "idle pins after reset", int'(hold), 0);

        for (int i = 0; i < NV; i++) begin
            run(VEC[i], 1'b0, 1'b0);
            @(negedge clk);
        end

        // R9: flip mode and durations mid-cycle
        fv = '{1'b1, 1'b1, 2'd1, 3'd1, 16'h7007, 16'h2222, 16'h0000, 4'd0};
        run(fv, 1'b1, 1'b0);
        @(negedge clk);
        fv = '{1'b0, 1'b0, 2'd2, 3'd3, 16'h7107, 16'h0000, 16'h9999, 4'd2};
        run(fv, 1'b1, 1'b0);
        @(negedge clk);

        // R8: request held high across back-to-back cycles
        kv = '{1'b0, 1'b0, 2'd0, 3'd1, 16'h8008, 16'h0000, 16'h4242, 4'd0};
        run(kv, 1'b0, 1'b1);
        kv = '{1'b0, 1'b1, 2'd1, 3'd0, 16'h8108, 16'h3333, 16'h0000, 4'd0};
        run(kv, 1'b0, 1'b1);
        kv = '{1'b1, 1'b0, 2'd1, 3'd1, 16'h8208, 16'h0000, 16'h1357, 4'd0};
        run(kv, 1'b0, 1'b0);
        @(negedge clk);

        // R1: reset in the middle of a cycle returns pins to idle
        kv = '{1'b1, 1'b1, 2'd3, 3'd7, 16'h9009, 16'h4444, 16'h0000, 4'd0};
        cfg_intel = kv.intel; cfg_adur = kv.adur; cfg_ddur = kv.ddur;
        req_write = kv.write; req_addr = kv.addr; req_wdata = kv.wdata;
        set_grant(1'b1);
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        chk(!hold && breq_n && ale_n && rd_n && wr_n && !ad_oe && !req_ack,
            "R1", "pins after mid-cycle reset", int'(hold), 0);
        rst = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule